// File: doc/BRIEF.md
# CAN Bit Timing Engine

This block turns a system clock and a packed bit timing word into the quantum-level timing of a CAN node. A programmable prescaler divides the clock into time quanta. A small state machine walks through each bit one quantum at a time: the single synchronization quantum, the combined propagation and first phase segment, and the second phase segment. At the end of the first segment it strobes a sample point and latches the bus level. When the second segment ends it strobes the transmit point, because the processing time after sampling is zero quanta.

The receive line is first passed through a two-flop synchronizer. It is then checked once per quantum for a falling transition, from recessive (1) to dominant (0). If the hard-sync enable from the frame logic is high, such a transition restarts the bit timing. If it is low, the block resynchronizes instead: it stretches or trims the current bit by the measured phase error, limited by the jump width. Frame decoding, stuffing, CRC and error handling sit in the bit-stream logic outside this block.

Top module: `can_bit_timer`

## Requirements
- R1: With the prescaler field `cfg_word[5:0]` holding P, `tq_tick` is high for one cycle in every P+1 clock cycles.
- R2: The fields are decoded as follows: `cfg_word[11:8]` is TSEG1-1, `cfg_word[14:12]` is TSEG2-1 and `cfg_word[7:6]` is SJW-1. With no synchronizing edge, sample points are (TSEG1+TSEG2+1)·(P+1) cycles apart. For example, 0x1601 gives 20 cycles and 0x34DF gives 320 cycles.
- R3: The sample point falls at the end of the TSEG1 quanta that follow the sync quantum. `sample_pt` is a one-cycle pulse, and `rx_bit` takes the synchronized bus level only at that pulse.
- R4: `tx_pt` pulses when a bit begins, which is normally TSEG2 quanta after the sample point. It never coincides with `sample_pt`.
- R5: A synchronizing edge requires that `rx_bit` (the last sampled level) is recessive (1) and that the current quantum is dominant (0). An edge that lands in the sync quantum changes no timing.
- R6: An edge in the first segment, e quanta after the sync quantum, delays the sample point by min(e, SJW) quanta.
- R7: An edge in the second segment, e quanta before the next sync quantum would start, advances the next sample point by min(e, SJW) quanta, and the sync quantum is skipped.
- R8: With `hsync_en`=1, an edge outside the sync quantum becomes the new sync quantum, and the sample point follows TSEG1 quanta later whatever the phase error.
- R9: Only one synchronization is applied between two consecutive sample points.
- R10: A stretched or trimmed bit affects only that bit. The next bit uses the nominal segment lengths.
- R11: During and after reset, `rx_bit` is 1 and both strobes are low until timing starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_raw | input | 1 | Unsynchronized CAN receive level, 1 = recessive |
| cfg_word | input | 15 | Packed bit timing configuration, held stable outside reset |
| hsync_en | input | 1 | Frame logic permits hard synchronization |
| tq_tick | output | 1 | One-cycle time-quantum tick |
| sample_pt | output | 1 | One-cycle sample-point strobe |
| rx_bit | output | 1 | Bus level captured at the last sample point |
| tx_pt | output | 1 | One-cycle strobe at the start of each bit |

## Verification
The bound checker watches the strobes on every cycle. It checks that each strobe follows a quantum tick, that `sample_pt` is a single-cycle pulse, that `rx_bit` holds between sample points, and that quantum ticks stay apart when the prescaler exceeds one. Where the sample point lands after a late, early or hard-synchronizing edge depends on where the edge fell and on SJW, so only the directed scenarios can show it. Each scenario places an edge at a chosen quantum and compares the measured sample position with the value computed from the requirements. The same applies to the single-synchronization rule and to the return to nominal bit length.

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_raw,
  input  logic [14:0] cfg_word,
  input  logic        hsync_en,
  output logic        tq_tick,
  output logic        sample_pt,
  output logic        rx_bit,
  output logic        tx_pt
);

  localparam int QW = 5;

  typedef enum logic [1:0] {ST_SYNC, ST_SEG1, ST_SEG2} seg_t;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic [5:0]             presc_q;
  logic [5:0]             brp_m1;
  logic [QW-1:0]          sjw, tseg1, tseg2;
  seg_t                   seg_q, seg_d;
  logic [QW-1:0]          cnt_q, cnt_d, lim_q, lim_d, cnt_inc;
  logic [QW-1:0]          err_early, adj_late, lim_tmp;
  logic                   skip_q, skip_d, synced_q, synced_d, skip_tmp;
  logic                   edge_det, sp_d, bs_d;

  assign brp_m1  = cfg_word[5:0];
  assign sjw     = {3'b000, cfg_word[7:6]}  + QW'(1);
  assign tseg1   = {1'b0,   cfg_word[11:8]} + QW'(1);
  assign tseg2   = {2'b00,  cfg_word[14:12]} + QW'(1);

  assign rx_s    = sync_q[SYNC_STAGES-1];
  assign tq_tick = (presc_q >= brp_m1);

  assign cnt_inc   = cnt_q + QW'(1);
  assign err_early = tseg2 - cnt_q;
  assign adj_late  = (cnt_inc < sjw) ? cnt_inc : sjw;
  assign edge_det  = rx_bit && !rx_s && !synced_q;

  always_comb begin
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    lim_d    = lim_q;
    skip_d   = skip_q;
    synced_d = synced_q;
    sp_d     = 1'b0;
    bs_d     = 1'b0;
    lim_tmp  = lim_q;
    skip_tmp = skip_q;
    if (tq_tick) begin
      unique case (seg_q)
        ST_SYNC: begin
          seg_d  = ST_SEG1;
          cnt_d  = '0;
          lim_d  = tseg1;
          skip_d = 1'b0;
          if (edge_det) synced_d = 1'b1;
        end
        ST_SEG1: begin
          if (edge_det && hsync_en) begin
            cnt_d    = '0;
            lim_d    = tseg1;
            synced_d = 1'b1;
            bs_d     = 1'b1;
          end else begin
            if (edge_det) begin
              lim_tmp  = tseg1 + adj_late;
              synced_d = 1'b1;
            end
            if (cnt_inc >= lim_tmp) begin
              seg_d    = ST_SEG2;
              cnt_d    = '0;
              lim_d    = tseg2;
              sp_d     = 1'b1;
              synced_d = 1'b0;
            end else begin
              cnt_d = cnt_inc;
              lim_d = lim_tmp;
            end
          end
        end
        default: begin
          if (edge_det && (hsync_en || err_early <= sjw)) begin
            seg_d    = ST_SEG1;
            cnt_d    = '0;
            lim_d    = tseg1;
            skip_d   = 1'b0;
            synced_d = 1'b1;
            bs_d     = 1'b1;
          end else begin
            if (edge_det) begin
              lim_tmp  = tseg2 + QW'(1) - sjw;
              skip_tmp = 1'b1;
              synced_d = 1'b1;
            end
            if (cnt_inc >= lim_tmp) begin
              bs_d   = 1'b1;
              cnt_d  = '0;
              skip_d = 1'b0;
              lim_d  = tseg1;
              seg_d  = skip_tmp ? ST_SEG1 : ST_SYNC;
            end else begin
              cnt_d  = cnt_inc;
              lim_d  = lim_tmp;
              skip_d = skip_tmp;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q    <= '1;
      presc_q   <= '0;
      seg_q     <= ST_SYNC;
      cnt_q     <= '0;
      lim_q     <= '0;
      skip_q    <= 1'b0;
      synced_q  <= 1'b0;
      sample_pt <= 1'b0;
      tx_pt     <= 1'b0;
      rx_bit    <= 1'b1;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], rx_raw};
      presc_q   <= tq_tick ? '0 : presc_q + 6'd1;
      seg_q     <= seg_d;
      cnt_q     <= cnt_d;
      lim_q     <= lim_d;
      skip_q    <= skip_d;
      synced_q  <= synced_d;
      sample_pt <= sp_d;
      tx_pt     <= bs_d;
      if (sp_d) rx_bit <= rx_s;
    end
  end

endmodule

module can_bit_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [14:0] cfg_word,
  input logic        tq_tick,
  input logic        sample_pt,
  input logic        tx_pt,
  input logic        rx_bit
);

  assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word[5:0] != 6'd0 && tq_tick) |=> !tq_tick);

  assert_sp_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |-> $past(tq_tick));

  assert_sp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_pt |=> !sample_pt);

  assert_bit_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_pt |-> $stable(rx_bit));

  assert_no_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_pt && tx_pt));

  assert_tx_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pt |-> $past(tq_tick));

endmodule

bind can_bit_timer can_bit_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .tq_tick(tq_tick),
  .sample_pt(sample_pt), .tx_pt(tx_pt), .rx_bit(rx_bit)
);

// File: tb/can_bit_timer_bench.sv
`timescale 1ns/1ps
module can_bit_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_raw = 1'b1;
  logic [14:0] cfg_word = 15'h3640;
  logic        hsync_en = 1'b0;
  logic        tq_tick, sample_pt, rx_bit, tx_pt;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int log_sp [1024];
  int log_tx [1024];
  int sp_n = 0;
  int tx_n = 0;
  int a0 = 0;
  int sp_base = 0;
  int tx_base = 0;
  bit done = 1'b0;

  can_bit_timer u_can_bit_timer (
    .clk(clk), .rst_n(rst_n), .rx_raw(rx_raw), .cfg_word(cfg_word),
    .hsync_en(hsync_en), .tq_tick(tq_tick), .sample_pt(sample_pt),
    .rx_bit(rx_bit), .tx_pt(tx_pt)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (sample_pt) begin log_sp[sp_n % 1024] = cyc; sp_n = sp_n + 1; end
    if (tx_pt)     begin log_tx[tx_n % 1024] = cyc; tx_n = tx_n + 1; end
  end

  always @(posedge clk) begin
    if (cyc >= 150000 && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [14:0] w);
    rst_n = 1'b0;
    cfg_word = w;
    rx_raw = 1'b1;
    hsync_en = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
  endtask

  task automatic anchor();
    int n0;
    n0 = sp_n;
    while (sp_n == n0) step();
    a0 = log_sp[(sp_n - 1) % 1024];
    sp_base = sp_n;
    tx_base = tx_n;
  endtask

  task automatic set_rx_at(int d, logic v);
    while (cyc - a0 < d) step();
    rx_raw = v;
  endtask

  task automatic get_sp(int k, output int p);
    while (sp_n < sp_base + k) step();
    p = log_sp[(sp_base + k - 1) % 1024] - a0;
  endtask

  task automatic get_tx(output int p);
    while (tx_n < tx_base + 1) step();
    p = log_tx[tx_base % 1024] - a0;
  endtask

  task automatic idle();
    rx_raw = 1'b1;
    hsync_en = 1'b0;
    repeat (3) anchor();
  endtask

  task automatic test_reset();
    rst_n = 1'b0;
    repeat (3) step();
    check("R11 rx_bit in reset", int'(rx_bit), 1);
    check("R11 sample_pt in reset", int'(sample_pt), 0);
    check("R11 tx_pt in reset", int'(tx_pt), 0);
  endtask

  task automatic test_nominal();
    int p;
    do_reset(15'h3640);
    idle();
    anchor();
    get_tx(p);
    check("R4 tx_pt offset after sample", p, 4);
    get_sp(1, p);
    check("R2 nominal spacing 12 quanta", p, 12);
    check("R3 sampled recessive", int'(rx_bit), 1);
  endtask

  task automatic test_prescaler();
    int n, p;
    do_reset(15'h3643);
    idle();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      if (tq_tick) n = n + 1;
      step();
    end
    check("R1 ticks in 40 cycles at P=3", n, 10);
    anchor();
    get_sp(1, p);
    check("R2 spacing with prescale 4", p, 48);
  endtask

  task automatic test_words();
    int p;
    do_reset(15'h1601);
    idle();
    anchor();
    get_sp(1, p);
    check("R2 word 0x1601 spacing", p, 20);
    do_reset(15'h34DF);
    anchor();
    anchor();
    get_sp(1, p);
    check("R2 word 0x34DF spacing", p, 320);
    do_reset(15'h3640);
  endtask

  task automatic edge_case(string req, bit hs, int j, int k, int exp);
    int p;
    idle();
    hsync_en = hs;
    anchor();
    set_rx_at(j - 3, 1'b0);
    get_sp(k, p);
    check(req, p, exp);
    hsync_en = 1'b0;
  endtask

  task automatic test_late_restore();
    int p;
    idle();
    anchor();
    set_rx_at(7, 1'b0);
    get_sp(1, p);
    check("R6 late e=5 capped at SJW", p, 14);
    get_sp(2, p);
    check("R10 next bit nominal", p, 26);
    check("R3 sampled dominant", int'(rx_bit), 0);
  endtask

  task automatic test_one_sync();
    int p;
    idle();
    anchor();
    set_rx_at(3, 1'b0);
    set_rx_at(4, 1'b1);
    set_rx_at(5, 1'b0);
    get_sp(1, p);
    check("R9 second edge ignored", p, 13);
  endtask

  task automatic test_no_edge_after_dominant();
    int p;
    idle();
    rx_raw = 1'b0;
    anchor();
    anchor();
    anchor();
    set_rx_at(0, 1'b1);
    set_rx_at(1, 1'b0);
    get_sp(1, p);
    check("R5 no edge after dominant sample", p, 12);
    check("R5 sampled bit dominant", int'(rx_bit), 0);
  endtask

  initial begin
    test_reset();
    test_nominal();
    test_prescaler();
    test_words();
    edge_case("R5 edge in sync quantum", 1'b0, 5, 1, 12);
    edge_case("R6 late e=1", 1'b0, 6, 1, 13);
    edge_case("R6 late e=2", 1'b0, 7, 1, 14);
    test_late_restore();
    edge_case("R7 early e=2", 1'b0, 3, 1, 10);
    edge_case("R7 early e=1", 1'b0, 16, 2, 23);
    edge_case("R7 early e=4 capped", 1'b0, 13, 2, 22);
    edge_case("R7 early e=3 capped", 1'b0, 14, 2, 22);
    edge_case("R8 hard sync in seg1", 1'b1, 10, 1, 17);
    edge_case("R8 hard sync in seg2", 1'b1, 14, 2, 21);
    test_one_sync();
    test_no_edge_after_dominant();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule